// File: doc/BRIEF.md
# Hardwired Instruction Control Sequencer

This block is the control unit of a small accumulator machine. It turns the 4-bit opcode into a fixed sequence of control words, one word per clock tick. Each word carries an encoded 3-bit bus source select, an encoded 3-bit bus destination select, one-hot ALU select lines and a strobe that clears the timing counter. The control words come from combinational terms of the current timing step and the opcode. There is no stored microprogram.

The timing counter sits at step 0 until `start` is raised. The opcode is decoded live in step 0 and captured on that same edge, so later steps use the captured value. Every instruction ends with a tick that raises `cnt_clr` and `done`, and the counter returns to step 0 on the next edge. The bus destination that takes memory data is address 3. The destination for the operand address is address 1. The instruction register is bus source 7.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While `rst` is high, every output (strobes, selects, ALU lines, `cnt_clr`, `done`) is low.
- R2: When idle (counter at step 0 and `start` low), `tstrobe` is 0001 and every control line is low. The counter stays at step 0 until `start` is high.
- R3: Exactly one `tstrobe` bit is high outside reset, and bit k marks step k. While an instruction runs, the step advances by one per clock.
- R4: ADD (opcode 0x3) drives, per step: step 0 rd_sel=7 and wr_sel=1; step 1 rd_sel=0 and wr_sel=3; step 2 alu_sel=0001 (add); step 3 `cnt_clr`. Every other line is low in each of these steps.
- R5: SUBT (opcode 0x4) follows the ADD sequence, except that step 2 drives alu_sel=0010 (subtract).
- R6: CLEAR (opcode 0xA) drives alu_sel=0100 (clear) at step 0 and `cnt_clr` at step 1, with all other lines low.
- R7: Any other opcode drives only `cnt_clr` at step 0.
- R8: A tick with `cnt_clr` high returns the counter to step 0 on the next edge. `done` is high in exactly the ticks where `cnt_clr` is high, so it is a one-cycle pulse.
- R9: At most one of alu_sel[3:0] is high, and alu_sel[3] (unused) is never high.
- R10: Opcode changes after step 0 have no effect on the rest of the sequence.
- R11: Parameter `STEPS` (4 or 8) sets the width of `tstrobe` and the counter range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode of the instruction to run |
| start | input | 1 | Begin an instruction from step 0 |
| tstrobe | output | STEPS | One-hot timing strobes |
| rd_sel | output | 3 | Encoded bus source select |
| wr_sel | output | 3 | Encoded bus destination select |
| alu_sel | output | 4 | ALU select: bit0 add, bit1 subtract, bit2 clear, bit3 unused |
| cnt_clr | output | 1 | Timing counter clear strobe |
| done | output | 1 | Instruction finished this tick |

## Verification
The bench changes the opcode to random values after step 0. A design that decodes the live opcode instead of the captured one would then branch mid-sequence. It holds `start` low at idle for several cycles, which catches a counter that free-runs. It checks that each sequence ends exactly at its clear tick and is followed by step 0. An off-by-one step or a missing clear would show up as the wrong control word or a stray strobe. Unknown opcodes are drawn at random to show that they retire in one tick and raise no ALU line.

// File: rtl/hw_seq_pkg.sv
package hw_seq_pkg;

    localparam logic [3:0] OP_ADD  = 4'h3;
    localparam logic [3:0] OP_SUBT = 4'h4;
    localparam logic [3:0] OP_CLR  = 4'hA;

    localparam logic [2:0] LOC_NONE = 3'd0;
    localparam logic [2:0] LOC_ADDR = 3'd1;
    localparam logic [2:0] LOC_DATA = 3'd3;
    localparam logic [2:0] LOC_INST = 3'd7;

    typedef enum logic [3:0] {
        ALU_NOP = 4'b0000,
        ALU_ADD = 4'b0001,
        ALU_SUB = 4'b0010,
        ALU_CLR = 4'b0100
    } alu_e;

    typedef struct packed {
        logic [2:0] rd;
        logic [2:0] wr;
        alu_e       alu;
        logic       clr;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '{rd: LOC_NONE, wr: LOC_NONE, alu: ALU_NOP, clr: 1'b0};

    // Control word for one step of an instruction.
    function automatic ctl_word_t step_word(input logic [3:0] op, input logic [2:0] step);
        ctl_word_t w;
        w = CTL_IDLE;
        unique case (op)
            OP_ADD, OP_SUBT: begin
                case (step)
                    3'd0: begin w.rd = LOC_INST; w.wr = LOC_ADDR; end
                    3'd1: w.wr = LOC_DATA;
                    3'd2: w.alu = (op == OP_ADD) ? ALU_ADD : ALU_SUB;
                    default: w.clr = 1'b1;
                endcase
            end
            OP_CLR: begin
                if (step == 3'd0) w.alu = ALU_CLR;
                else              w.clr = 1'b1;
            end
            default: w.clr = 1'b1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hw_seq_counter.sv
module hw_seq_counter #(
    parameter int STEPS = 4,
    localparam int CW = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clr,
    input  logic [3:0]       opcode,
    output logic [CW-1:0]    step,
    output logic             active,
    output logic [3:0]       op_eff,
    output logic [STEPS-1:0] tstrobe
);
    logic [CW-1:0] cnt_q;
    logic [3:0]    op_q;
    logic          at_first;

    assign at_first = (cnt_q == '0);
    assign active   = !at_first || start;
    assign op_eff   = at_first ? opcode : op_q;
    assign step     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            op_q  <= '0;
        end else begin
            if (at_first && start) op_q <= opcode;
            if (clr)         cnt_q <= '0;
            else if (active) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tstrobe = '0;
        tstrobe[cnt_q] = 1'b1;
    end

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot(tstrobe));
    assert_clear_returns_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (at_first && !start) |=> (cnt_q == '0));
    assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_op_held_R10: assert property (@(posedge clk) disable iff (rst)
        (!at_first && ($past(cnt_q) != '0)) |-> $stable(op_q));
endmodule

// File: rtl/hw_seq_decoder.sv
module hw_seq_decoder
    import hw_seq_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [3:0]    op,
    input  logic [CW-1:0] step,
    output ctl_word_t     word
);
    logic [2:0] step3;

    generate
        if (CW >= 3) begin : g_wide
            assign step3 = step[2:0];
        end else begin : g_narrow
            assign step3 = {{(3-CW){1'b0}}, step};
        end
    endgenerate

    assign word = active ? step_word(op, step3) : CTL_IDLE;

    assert_alu_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word.alu) && !word.alu[3]);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !active |-> (word == CTL_IDLE));
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
    import hw_seq_pkg::*;
#(
    parameter int STEPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       opcode,
    input  logic             start,
    output logic [STEPS-1:0] tstrobe,
    output logic [2:0]       rd_sel,
    output logic [2:0]       wr_sel,
    output logic [3:0]       alu_sel,
    output logic             cnt_clr,
    output logic             done
);
    localparam int CW = $clog2(STEPS);

    logic [CW-1:0]    step;
    logic             active;
    logic [3:0]       op_eff;
    logic [STEPS-1:0] strobe_raw;
    ctl_word_t        word;

    hw_seq_counter #(.STEPS(STEPS)) u_cnt (
        .clk(clk), .rst(rst), .start(start), .clr(word.clr), .opcode(opcode),
        .step(step), .active(active), .op_eff(op_eff), .tstrobe(strobe_raw)
    );

    hw_seq_decoder #(.CW(CW)) u_dec (
        .clk(clk), .rst(rst), .active(active), .op(op_eff), .step(step), .word(word)
    );

    always_comb begin
        if (rst) begin
            tstrobe = '0;
            rd_sel  = '0;
            wr_sel  = '0;
            alu_sel = '0;
            cnt_clr = 1'b0;
            done    = 1'b0;
        end else begin
            tstrobe = strobe_raw;
            rd_sel  = word.rd;
            wr_sel  = word.wr;
            alu_sel = word.alu;
            cnt_clr = word.clr;
            done    = word.clr;
        end
    end

    initial begin
        assert_param_R11: assert (STEPS == 4 || STEPS == 8);
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/sim_hw_seq_ctrl.sv
module sim_hw_seq_ctrl;
    localparam int STEPS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] opcode = '0;
    logic start = 1'b0;
    logic [STEPS-1:0] tstrobe;
    logic [2:0] rd_sel, wr_sel;
    logic [3:0] alu_sel;
    logic cnt_clr, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hw_seq_ctrl #(.STEPS(STEPS)) u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .start(start), .tstrobe(tstrobe),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .alu_sel(alu_sel), .cnt_clr(cnt_clr), .done(done)
    );

    // Expected packed word {strobe, rd, wr, alu, clr, done}.
    function automatic logic [STEPS+11:0] expect_word(input logic [3:0] op, input int st, input bit run);
        logic [2:0] r, w;
        logic [3:0] a;
        logic c;
        r = 0; w = 0; a = 0; c = 0;
        if (run) begin
            if (op == 4'h3 || op == 4'h4) begin
                if (st == 0) begin r = 7; w = 1; end
                else if (st == 1) w = 3;
                else if (st == 2) a = (op == 4'h3) ? 4'b0001 : 4'b0010;
                else c = 1;
            end else if (op == 4'hA) begin
                if (st == 0) a = 4'b0100; else c = 1;
            end else c = 1;
        end
        return {STEPS'(1) << st, r, w, a, c, c};
    endfunction

    task automatic check(input string req, input logic [STEPS+11:0] exp);
        logic [STEPS+11:0] act;
        act = {tstrobe, rd_sel, wr_sel, alu_sel, cnt_clr, done};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Run one instruction; start is pulsed for one cycle, then the opcode is scrambled.
    task automatic run_op(input logic [3:0] op, input bit scramble, input string req);
        int st;
        bit last;
        @(negedge clk);
        opcode = op;
        start  = 1'b1;
        st = 0;
        last = 1'b0;
        while (!last) begin
            #1;
            check(req, expect_word(op, st, 1'b1));
            last = (expect_word(op, st, 1'b1) & 1) != 0;
            @(negedge clk);
            start = 1'b0;
            if (scramble) opcode = 4'($urandom);
            st++;
        end
        #1;
        check("R8", expect_word(op, 0, 1'b0));
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: outputs quiet in reset
        start = 1'b1; opcode = 4'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", '0);
        rst = 1'b0; start = 1'b0;
        // R2: idle holds at step 0
        repeat (5) begin
            @(negedge clk); #1;
            check("R2", expect_word(4'h3, 0, 1'b0));
        end
        run_op(4'h3, 1'b0, "R4");
        run_op(4'h4, 1'b0, "R5");
        run_op(4'hA, 1'b0, "R6");
        run_op(4'h0, 1'b0, "R7");
        run_op(4'hF, 1'b0, "R7");
        run_op(4'h3, 1'b1, "R10");
        run_op(4'h4, 1'b1, "R10");
        // R11: strobe width matches parameter
        n_tests++;
        if ($bits(tstrobe) != STEPS) begin
            n_fail++;
            $display("FAIL R11: width %0d expected %0d", $bits(tstrobe), STEPS);
        end
        // R3/R9: random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] op;
            op = 4'($urandom);
            if (i % 3 == 0) op = ($urandom % 2) ? 4'h3 : 4'h4;
            run_op(op, ($urandom % 2) == 1, "R3");
            if ($urandom % 4 == 0) begin
                @(negedge clk); #1;
                check("R2", expect_word(4'h0, 0, 1'b0));
            end
        end
        // R1: reset in the middle of an instruction
        @(negedge clk); opcode = 4'h3; start = 1'b1;
        @(negedge clk); start = 1'b0; rst = 1'b1;
        #1; check("R1", '0);
        @(negedge clk); rst = 1'b0;
        #1; check("R1", expect_word(4'h3, 0, 1'b0));
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule